// File: doc/BRIEF.md
# Memory-Reference Instruction Sequencer

This block runs the memory-operand instructions of a small word-oriented processor. A machine word is 18 bits: bit 17 carries parity and bits 16..0 carry data. The sequencer fetches each instruction from a synchronous single-port memory and forms the operand address, either in page zero or in the page that holds the program counter. It can follow one level of indirection. It then executes the instruction against two 17-bit accumulators, a carry flag and a greater-than flag. Instructions from other groups are handed out on a one-cycle pass port and the program counter moves past them.

Each instruction moves through named states. FETCH issues the read at the program counter. DECODE takes the instruction word, forms the page address and goes to FETCH (passed group), INDIRECT (I set) or EXECUTE. INDIRECT reads the pointer word and goes to EXECUTE. EXECUTE uses the operand and updates the registers, flags and program counter. It then goes to WRITEBACK (call, increment/decrement-skip, stores) or back to FETCH. WRITEBACK performs the memory write and returns to FETCH. The registered `retire` pulse appears in the cycle after the last state of every instruction, and it shows the updated architectural state.

Top module: `mref_sequencer`

## Requirements
- R1: While reset is asserted, A, B, carry, greater-than, parity error, retire and pass are all 0, the PC is RESET_PC (1024), and the block drives a read at the PC.
- R2: In the data field, bits 16..12 hold the opcode, bit 11 is the indirect flag I, bit 10 is the zero-page flag Z and bits 9..0 are the offset. Opcode values in decimal: loads 17 (A) and 18 (B); stores 21 (A) and 22 (B); add 9/10 (A/B); subtract 11/12; add with carry 13/14; subtract with carry 15/16; compare 19/20; AND, OR and XOR into A are 6, 7 and 8; jump 2; call 3; increment-skip 4; decrement-skip 5.
- R3: With Z=1 the address is {00000, offset}. With Z=0 it is {PC[14:10], offset}.
- R4: With I=1 the word at the page address is read and its bits 14..0 become the operand address. This costs one extra cycle.
- R5: Cycles from one retire to the next: 2 for a passed instruction, 3 for a plain operand or jump, 4 for a store, call or inc/dec-skip. Indirection adds 1.
- R6: AND, OR and XOR combine A with the operand into A. Carry and greater-than are left unchanged.
- R7: Add forms A/B + M, subtract forms A/B + ~M + 1, and the carry forms use the current carry flag in place of the +1 or +0. The carry flag takes the carry out of bit 16 of the data.
- R8: Loads copy the operand into A or B. Stores write A or B to the operand address.
- R9: Compare sets greater-than to (register > operand, unsigned), skips when the two are equal and changes no register.
- R10: Increment-skip and decrement-skip write the operand ±1 (17-bit wrap) back and skip when the result is zero.
- R11: Jump loads the PC with the operand address. Call writes the call address + 1 to the operand address and continues at operand address + 1. An indirect jump through that word returns.
- R12: A taken skip advances the PC by 2. Otherwise the PC advances by 1.
- R13: Every written word has even parity over all 18 bits. A parity mismatch on an instruction, pointer or operand read sets parity_err, which stays set until reset.
- R14: Opcodes 0, 1 and 23..31 are not executed. They raise pass_valid with the 17-bit data word on pass_word, advance the PC by 1 and leave A, B and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 15 | Memory word address |
| mem_re | output | 1 | Read request; data returns the next cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 18 | Write word with parity in bit 17 |
| mem_rdata | input | 18 | Read word, valid the cycle after mem_re |
| reg_a | output | 17 | Accumulator A |
| reg_b | output | 17 | Accumulator B |
| flag_c | output | 1 | Carry flag |
| flag_gt | output | 1 | Greater-than flag |
| pc | output | 15 | Program counter |
| retire | output | 1 | Pulse: an instruction has completed |
| pass_valid | output | 1 | Pulse: a non-memory instruction is handed on |
| pass_word | output | 17 | Data bits of the handed-on instruction |
| parity_err | output | 1 | Sticky read-parity error |

## Verification
The assertions assume a memory that returns the addressed word exactly one cycle after a read request and never changes it in between. They also assume reset is held for at least one clock before the first check. The bench memory model follows that timing. Its program uses only addresses in pages zero and one, so words never collide. All program and data words carry correct parity except one operand that is made bad on purpose, and that operand is read last so that it cannot hide an earlier parity fault.

// File: rtl/mref_pkg.sv
package mref_pkg;

    localparam int OP_W = 5;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_INDIRECT,
        ST_EXECUTE,
        ST_WRITEBACK
    } seq_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_JUMP    = 5'd2,
        OP_CALL    = 5'd3,
        OP_INCSKIP = 5'd4,
        OP_DECSKIP = 5'd5,
        OP_ANDA    = 5'd6,
        OP_ORA     = 5'd7,
        OP_XORA    = 5'd8,
        OP_ADDA    = 5'd9,
        OP_ADDB    = 5'd10,
        OP_SUBA    = 5'd11,
        OP_SUBB    = 5'd12,
        OP_ADCA    = 5'd13,
        OP_ADCB    = 5'd14,
        OP_SBCA    = 5'd15,
        OP_SBCB    = 5'd16,
        OP_LOADA   = 5'd17,
        OP_LOADB   = 5'd18,
        OP_CMPA    = 5'd19,
        OP_CMPB    = 5'd20,
        OP_STOREA  = 5'd21,
        OP_STOREB  = 5'd22
    } mref_op_e;

    // True for every opcode this sequencer executes itself.
    function automatic logic is_mref(input logic [OP_W-1:0] op);
        return (op >= OP_JUMP) && (op <= OP_STOREB);
    endfunction

    // Opcodes that consume the data word found at the operand address.
    function automatic logic uses_operand(input logic [OP_W-1:0] op);
        return is_mref(op) && !(op inside {OP_JUMP, OP_CALL, OP_STOREA, OP_STOREB});
    endfunction

    // Opcodes that end with a memory write.
    function automatic logic uses_writeback(input logic [OP_W-1:0] op);
        return op inside {OP_CALL, OP_INCSKIP, OP_DECSKIP, OP_STOREA, OP_STOREB};
    endfunction

endpackage

// File: rtl/mref_parity.sv
module mref_parity #(
    parameter int DATA_W = 17,
    parameter bit ODD    = 1'b0
) (
    input  logic [DATA_W-1:0] data,
    output logic              par
);
    generate
        if (ODD) begin : g_odd
            assign par = ~(^data);
        end else begin : g_even
            assign par = ^data;
        end
    endgenerate
endmodule

// File: rtl/mref_addr_gen.sv
module mref_addr_gen #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 10
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              zero_page,
    input  logic [PAGE_W-1:0] offset,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int PNUM_W = ADDR_W - PAGE_W;

    logic [PNUM_W-1:0] page_sel;

    assign page_sel = zero_page ? '0 : cur_pc[ADDR_W-1:PAGE_W];
    assign eff_addr = {page_sel, offset};
endmodule

// File: rtl/mref_exec.sv
module mref_exec
    import mref_pkg::*;
#(
    parameter int DATA_W = 17
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_in,
    input  logic              gt_in,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] b_out,
    output logic              c_out,
    output logic              gt_out,
    output logic              skip,
    output logic [DATA_W-1:0] wb_data
);
    localparam int EXT_W = DATA_W + 1;

    logic              sel_b;
    logic              is_sub;
    logic              is_cform;
    logic [DATA_W-1:0] rsel;
    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [EXT_W-1:0]  sum;
    logic [DATA_W-1:0] inc_val;
    logic [DATA_W-1:0] dec_val;

    assign sel_b    = op inside {OP_ADDB, OP_SUBB, OP_ADCB, OP_SBCB, OP_LOADB, OP_CMPB, OP_STOREB};
    assign is_sub   = op inside {OP_SUBA, OP_SUBB, OP_SBCA, OP_SBCB};
    assign is_cform = op inside {OP_ADCA, OP_ADCB, OP_SBCA, OP_SBCB};
    assign rsel     = sel_b ? b_in : a_in;
    assign addend   = is_sub ? ~operand : operand;
    assign cin      = is_cform ? c_in : is_sub;
    assign sum      = {1'b0, rsel} + {1'b0, addend} + EXT_W'(cin);
    assign inc_val  = operand + DATA_W'(1);
    assign dec_val  = operand - DATA_W'(1);

    always_comb begin
        a_out   = a_in;
        b_out   = b_in;
        c_out   = c_in;
        gt_out  = gt_in;
        skip    = 1'b0;
        wb_data = operand;
        case (op)
            OP_ADDA, OP_SUBA, OP_ADCA, OP_SBCA: begin
                a_out = sum[DATA_W-1:0];
                c_out = sum[DATA_W];
            end
            OP_ADDB, OP_SUBB, OP_ADCB, OP_SBCB: begin
                b_out = sum[DATA_W-1:0];
                c_out = sum[DATA_W];
            end
            OP_ANDA: a_out = a_in & operand;
            OP_ORA:  a_out = a_in | operand;
            OP_XORA: a_out = a_in ^ operand;
            OP_LOADA: a_out = operand;
            OP_LOADB: b_out = operand;
            OP_CMPA, OP_CMPB: begin
                gt_out = rsel > operand;
                skip   = rsel == operand;
            end
            OP_INCSKIP: begin
                wb_data = inc_val;
                skip    = inc_val == '0;
            end
            OP_DECSKIP: begin
                wb_data = dec_val;
                skip    = dec_val == '0;
            end
            OP_STOREA, OP_STOREB: wb_data = rsel;
            default: ;
        endcase
    end
endmodule

// File: rtl/mref_sequencer.sv
module mref_sequencer
    import mref_pkg::*;
#(
    parameter int DATA_W   = 17,
    parameter int ADDR_W   = 15,
    parameter int PAGE_W   = 10,
    parameter int RESET_PC = 1024,
    parameter bit PAR_ODD  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W:0]   mem_wdata,
    input  logic [DATA_W:0]   mem_rdata,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic              flag_c,
    output logic              flag_gt,
    output logic [ADDR_W-1:0] pc,
    output logic              retire,
    output logic              pass_valid,
    output logic [DATA_W-1:0] pass_word,
    output logic              parity_err
);
    localparam int OP_LSB  = DATA_W - OP_W;
    localparam int IND_BIT = OP_LSB - 1;
    localparam int ZP_BIT  = OP_LSB - 2;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, ea_q;
    logic [OP_W-1:0]   op_q;
    logic [DATA_W-1:0] a_q, b_q, wb_q, pass_word_q;
    logic              c_q, gt_q, perr_q, retire_q, pass_q;

    logic [DATA_W-1:0] rd_data;
    logic              rd_par_exp, rd_bad, rd_checked, wr_par;
    logic [OP_W-1:0]   dec_op;
    logic              dec_ind, dec_zp;
    logic [PAGE_W-1:0] dec_off;
    logic [ADDR_W-1:0] dec_ea;

    logic [DATA_W-1:0] x_a, x_b, x_wb;
    logic              x_c, x_gt, x_skip;

    assign rd_data = mem_rdata[DATA_W-1:0];
    assign dec_op  = rd_data[DATA_W-1:OP_LSB];
    assign dec_ind = rd_data[IND_BIT];
    assign dec_zp  = rd_data[ZP_BIT];
    assign dec_off = rd_data[PAGE_W-1:0];

    mref_parity #(.DATA_W(DATA_W), .ODD(PAR_ODD)) u_par_chk (
        .data (rd_data),
        .par  (rd_par_exp)
    );

    mref_parity #(.DATA_W(DATA_W), .ODD(PAR_ODD)) u_par_gen (
        .data (wb_q),
        .par  (wr_par)
    );

    mref_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .cur_pc    (pc_q),
        .zero_page (dec_zp),
        .offset    (dec_off),
        .eff_addr  (dec_ea)
    );

    mref_exec #(.DATA_W(DATA_W)) u_exec (
        .op      (op_q),
        .a_in    (a_q),
        .b_in    (b_q),
        .c_in    (c_q),
        .gt_in   (gt_q),
        .operand (rd_data),
        .a_out   (x_a),
        .b_out   (x_b),
        .c_out   (x_c),
        .gt_out  (x_gt),
        .skip    (x_skip),
        .wb_data (x_wb)
    );

    assign rd_bad     = rd_par_exp != mem_rdata[DATA_W];
    assign rd_checked = (state_q == ST_DECODE) || (state_q == ST_INDIRECT) ||
                        ((state_q == ST_EXECUTE) && uses_operand(op_q));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:     state_d = ST_DECODE;
            ST_DECODE: begin
                if (!is_mref(dec_op)) state_d = ST_FETCH;
                else if (dec_ind)     state_d = ST_INDIRECT;
                else                  state_d = ST_EXECUTE;
            end
            ST_INDIRECT:  state_d = ST_EXECUTE;
            ST_EXECUTE:   state_d = uses_writeback(op_q) ? ST_WRITEBACK : ST_FETCH;
            ST_WRITEBACK: state_d = ST_FETCH;
            default:      state_d = ST_FETCH;
        endcase
    end

    // Memory bus outputs per state
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = {wr_par, wb_q};
        unique case (state_q)
            ST_FETCH:  mem_re = 1'b1;
            ST_DECODE: begin
                if (is_mref(dec_op)) begin
                    mem_addr = dec_ea;
                    mem_re   = dec_ind || uses_operand(dec_op);
                end
            end
            ST_INDIRECT: begin
                mem_addr = rd_data[ADDR_W-1:0];
                mem_re   = uses_operand(op_q);
            end
            ST_EXECUTE: ;
            ST_WRITEBACK: begin
                mem_addr = ea_q;
                mem_we   = 1'b1;
            end
            default: ;
        endcase
    end

    // Architectural state and retire reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= ADDR_W'(RESET_PC);
            ea_q        <= '0;
            op_q        <= '0;
            a_q         <= '0;
            b_q         <= '0;
            wb_q        <= '0;
            c_q         <= 1'b0;
            gt_q        <= 1'b0;
            perr_q      <= 1'b0;
            retire_q    <= 1'b0;
            pass_q      <= 1'b0;
            pass_word_q <= '0;
        end else begin
            retire_q <= 1'b0;
            pass_q   <= 1'b0;
            if (rd_checked && rd_bad) perr_q <= 1'b1;
            unique case (state_q)
                ST_FETCH: ;
                ST_DECODE: begin
                    op_q <= dec_op;
                    ea_q <= dec_ea;
                    if (!is_mref(dec_op)) begin
                        pc_q        <= pc_q + ADDR_W'(1);
                        retire_q    <= 1'b1;
                        pass_q      <= 1'b1;
                        pass_word_q <= rd_data;
                    end
                end
                ST_INDIRECT: ea_q <= rd_data[ADDR_W-1:0];
                ST_EXECUTE: begin
                    a_q  <= x_a;
                    b_q  <= x_b;
                    c_q  <= x_c;
                    gt_q <= x_gt;
                    wb_q <= x_wb;
                    if (op_q == OP_JUMP) begin
                        pc_q <= ea_q;
                    end else if (op_q == OP_CALL) begin
                        wb_q <= DATA_W'(pc_q + ADDR_W'(1));
                        pc_q <= ea_q + ADDR_W'(1);
                    end else begin
                        pc_q <= pc_q + (x_skip ? ADDR_W'(2) : ADDR_W'(1));
                    end
                    if (!uses_writeback(op_q)) retire_q <= 1'b1;
                end
                ST_WRITEBACK: retire_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign reg_a      = a_q;
    assign reg_b      = b_q;
    assign flag_c     = c_q;
    assign flag_gt    = gt_q;
    assign pc         = pc_q;
    assign retire     = retire_q;
    assign pass_valid = pass_q;
    assign pass_word  = pass_word_q;
    assign parity_err = perr_q;

    // R13
    parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_q |=> perr_q);

    // R13
    write_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((^mem_wdata) == PAR_ODD));

    // R5
    write_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(state_q) == ST_EXECUTE));

    // R5
    retire_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_q |-> (state_q == ST_FETCH));

    // R14
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EXECUTE) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));

    // R12
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_FETCH, ST_INDIRECT, ST_WRITEBACK}) |=> $stable(pc_q));

    // R8
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

endmodule

// File: tb/test_mref_sequencer.sv
module test_mref_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [17:0] mem_wdata;
    logic [17:0] mem_rdata = '0;
    logic [16:0] reg_a, reg_b, pass_word;
    logic        flag_c, flag_gt, retire, pass_valid, parity_err;
    logic [14:0] pc;

    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [17:0] ld_data = '0;
    logic [17:0] mem [0:4095];

    int total = 0;
    int bad = 0;
    int cyc_cnt = 0;

    typedef struct {
        string       tag;
        logic [14:0] pc;
        logic [16:0] a;
        logic [16:0] b;
        logic        c;
        logic        gt;
        logic        pass;
        logic [16:0] pw;
        logic        perr;
        int          cyc;
    } exp_t;

    exp_t sb[$];

    // opcode values from R2
    localparam logic [4:0] JMP = 5'd2, CAL = 5'd3, ISZ = 5'd4, DSZ = 5'd5;
    localparam logic [4:0] ANA = 5'd6, ORA = 5'd7, XRA = 5'd8;
    localparam logic [4:0] ADA = 5'd9, ADB = 5'd10, SBA = 5'd11, SBB = 5'd12;
    localparam logic [4:0] ACA = 5'd13, ACB = 5'd14, SCA = 5'd15, SCB = 5'd16;
    localparam logic [4:0] LDA = 5'd17, LDB = 5'd18, CPA = 5'd19, CPB = 5'd20;
    localparam logic [4:0] STA = 5'd21, STB = 5'd22;

    always #10 clk = ~clk;

    mref_sequencer i_mref_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .reg_a      (reg_a),
        .reg_b      (reg_b),
        .flag_c     (flag_c),
        .flag_gt    (flag_gt),
        .pc         (pc),
        .retire     (retire),
        .pass_valid (pass_valid),
        .pass_word  (pass_word),
        .parity_err (parity_err)
    );

    // synchronous memory model: read data one cycle after request
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    end

    function automatic logic [17:0] dw(input logic [16:0] v);
        return {^v, v};
    endfunction

    function automatic logic [17:0] ins(input logic [4:0] op, input logic i,
                                        input logic z, input logic [9:0] off);
        return dw({op, i, z, off});
    endfunction

    task automatic put(input int addr, input logic [17:0] w);
        ld_en   = 1'b1;
        ld_addr = 12'(addr);
        ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input string tag, input int p, input logic [16:0] a,
                        input logic [16:0] b, input logic c, input logic gt,
                        input logic pass, input logic [16:0] pw,
                        input logic perr, input int cyc);
        exp_t e;
        e.tag = tag; e.pc = 15'(p); e.a = a; e.b = b; e.c = c; e.gt = gt;
        e.pass = pass; e.pw = pw; e.perr = perr; e.cyc = cyc;
        sb.push_back(e);
    endtask

    // monitor: compare each retired instruction against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                cyc_cnt++;
                if (retire) begin
                    if (sb.size() > 0) begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(e.tag, "pc", 32'(pc), 32'(e.pc));
                        chk(e.tag, "A", 32'(reg_a), 32'(e.a));
                        chk(e.tag, "B", 32'(reg_b), 32'(e.b));
                        chk(e.tag, "C", 32'(flag_c), 32'(e.c));
                        chk(e.tag, "GT", 32'(flag_gt), 32'(e.gt));
                        chk(e.tag, "pass", 32'(pass_valid), 32'(e.pass));
                        chk(e.tag, "perr", 32'(parity_err), 32'(e.perr));
                        if (e.pass) chk(e.tag, "pass_word", 32'(pass_word), 32'(e.pw));
                        if (e.cyc != 0) chk({e.tag, " R5"}, "cycles", 32'(cyc_cnt), 32'(e.cyc));
                    end
                    cyc_cnt = 0;
                end
            end
        end
    end

    initial begin
        @(negedge clk);
        // zero-page data
        put(10, dw(17'h1FFFF));
        put(11, dw(17'h00001));
        put(12, dw(17'h0F0F0));
        put(13, dw(17'h12345));
        put(14, dw(17'h00001));
        put(15, dw(17'h1FFFF));
        put(16, dw(17'h00005));
        put(20, dw(17'd1224));
        put(21, dw(17'h0));
        put(23, dw(17'd1234));
        put(24, {~(^17'h00ABC), 17'h00ABC});
        put(200, dw(17'h00555));
        put(1224, dw(17'h00777));
        put(1324, dw(17'h0));
        // program in page one
        put(1024, ins(LDA, 0, 1, 10));
        put(1025, ins(ADA, 0, 1, 11));
        put(1026, ins(LDB, 0, 1, 13));
        put(1027, ins(ACB, 0, 1, 11));
        put(1028, ins(SBA, 0, 1, 11));
        put(1029, ins(SCB, 0, 1, 11));
        put(1030, ins(ANA, 0, 1, 12));
        put(1031, ins(ORA, 0, 1, 11));
        put(1032, ins(XRA, 0, 1, 10));
        put(1033, ins(LDA, 1, 1, 20));
        put(1034, ins(CPA, 0, 1, 11));
        put(1035, ins(CPB, 0, 0, 200));
        put(1036, ins(CPA, 0, 0, 200));
        put(1037, ins(LDA, 0, 1, 10));
        put(1038, ins(ISZ, 0, 1, 15));
        put(1039, ins(LDA, 0, 1, 10));
        put(1040, ins(ISZ, 0, 1, 16));
        put(1041, ins(DSZ, 0, 1, 14));
        put(1042, ins(LDA, 0, 1, 10));
        put(1043, ins(STA, 0, 1, 21));
        put(1044, ins(LDB, 0, 1, 21));
        put(1045, ins(LDA, 0, 1, 16));
        put(1046, ins(ACA, 0, 1, 10));
        put(1047, ins(SCA, 0, 1, 11));
        put(1048, ins(SBB, 0, 1, 10));
        put(1049, ins(STB, 1, 1, 23));
        put(1050, ins(LDA, 0, 0, 210));
        put(1051, ins(CAL, 0, 0, 300));
        put(1052, ins(DSZ, 0, 1, 16));
        put(1053, dw(17'h000A5));
        put(1054, ins(LDA, 0, 1, 24));
        put(1055, ins(JMP, 0, 0, 31));
        put(1325, ins(LDB, 0, 1, 11));
        put(1326, ins(JMP, 1, 0, 300));

        push("R8 R3 load zero page",      1025, 17'h1FFFF, 17'h0,     0, 0, 0, 0, 0, 0);
        push("R7 add carry out",          1026, 17'h0,     17'h0,     1, 0, 0, 0, 0, 3);
        push("R8 load B",                 1027, 17'h0,     17'h12345, 1, 0, 0, 0, 0, 3);
        push("R7 add B with carry",       1028, 17'h0,     17'h12347, 0, 0, 0, 0, 0, 3);
        push("R7 subtract borrow",        1029, 17'h1FFFF, 17'h12347, 0, 0, 0, 0, 0, 3);
        push("R7 subtract B with carry",  1030, 17'h1FFFF, 17'h12345, 1, 0, 0, 0, 0, 3);
        push("R6 and",                    1031, 17'h0F0F0, 17'h12345, 1, 0, 0, 0, 0, 3);
        push("R6 or",                     1032, 17'h0F0F1, 17'h12345, 1, 0, 0, 0, 0, 3);
        push("R6 xor",                    1033, 17'h10F0E, 17'h12345, 1, 0, 0, 0, 0, 3);
        push("R4 indirect load",          1034, 17'h00777, 17'h12345, 1, 0, 0, 0, 0, 4);
        push("R9 compare greater",        1035, 17'h00777, 17'h12345, 1, 1, 0, 0, 0, 3);
        push("R9 R3 compare current page",1036, 17'h00777, 17'h12345, 1, 1, 0, 0, 0, 3);
        push("R9 R12 compare equal skip", 1038, 17'h00777, 17'h12345, 1, 0, 0, 0, 0, 3);
        push("R10 R12 inc to zero skip",  1040, 17'h00777, 17'h12345, 1, 0, 0, 0, 0, 4);
        push("R10 inc no skip",           1041, 17'h00777, 17'h12345, 1, 0, 0, 0, 0, 4);
        push("R10 dec to zero skip",      1043, 17'h00777, 17'h12345, 1, 0, 0, 0, 0, 4);
        push("R8 store A",                1044, 17'h00777, 17'h12345, 1, 0, 0, 0, 0, 4);
        push("R8 reload stored word",     1045, 17'h00777, 17'h00777, 1, 0, 0, 0, 0, 3);
        push("R10 reload incremented",    1046, 17'h00006, 17'h00777, 1, 0, 0, 0, 0, 3);
        push("R7 add A with carry",       1047, 17'h00006, 17'h00777, 1, 0, 0, 0, 0, 3);
        push("R7 subtract A with carry",  1048, 17'h00005, 17'h00777, 1, 0, 0, 0, 0, 3);
        push("R7 subtract B",             1049, 17'h00005, 17'h00778, 0, 0, 0, 0, 0, 3);
        push("R4 R8 indirect store",      1050, 17'h00005, 17'h00778, 0, 0, 0, 0, 0, 5);
        push("R3 load current page",      1051, 17'h00778, 17'h00778, 0, 0, 0, 0, 0, 3);
        push("R11 call",                  1325, 17'h00778, 17'h00778, 0, 0, 0, 0, 0, 4);
        push("R11 subroutine body",       1326, 17'h00778, 17'h00001, 0, 0, 0, 0, 0, 3);
        push("R11 R13 return via pointer",1052, 17'h00778, 17'h00001, 0, 0, 0, 0, 0, 4);
        push("R10 dec no skip",           1053, 17'h00778, 17'h00001, 0, 0, 0, 0, 0, 4);
        push("R14 pass other group",      1054, 17'h00778, 17'h00001, 0, 0, 1, 17'h000A5, 0, 2);
        push("R13 bad parity operand",    1055, 17'h00ABC, 17'h00001, 0, 0, 0, 0, 1, 3);
        push("R11 R13 jump sticky error", 1055, 17'h00ABC, 17'h00001, 0, 0, 0, 0, 1, 3);

        // R1 reset state
        chk("R1", "A", 32'(reg_a), 0);
        chk("R1", "B", 32'(reg_b), 0);
        chk("R1", "C/GT", 32'({flag_c, flag_gt}), 0);
        chk("R1", "pc", 32'(pc), 1024);
        chk("R1", "perr/retire/pass", 32'({parity_err, retire, pass_valid}), 0);
        chk("R1", "fetch read", 32'({mem_re, mem_we, mem_addr}), 32'({1'b1, 1'b0, 15'd1024}));

        rst_n = 1'b1;
        for (int i = 0; i < 5000 && sb.size() != 0; i++) @(negedge clk);
        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog actual=%0d expected=0 pending items", sb.size());
        end
        repeat (2) @(negedge clk);

        chk("R10 inc wrap written", "mem[15]", 32'(mem[15]), 32'(dw(17'h0)));
        chk("R10 dec written", "mem[14]", 32'(mem[14]), 32'(dw(17'h0)));
        chk("R10 inc then dec", "mem[16]", 32'(mem[16]), 32'(dw(17'h5)));
        chk("R8 R13 store A word", "mem[21]", 32'(mem[21]), 32'(dw(17'h777)));
        chk("R4 R13 indirect store word", "mem[1234]", 32'(mem[1234]), 32'(dw(17'h778)));
        chk("R11 R13 return word", "mem[1324]", 32'(mem[1324]), 32'(dw(17'd1052)));
        chk("R3 page zero untouched", "mem[200]", 32'(mem[200]), 32'(dw(17'h555)));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule